// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches an already aligned T1 receive stream and decides whether the far end is sending a remote (yellow) alarm. The frame aligner upstream presents each payload bit with its channel number and its bit position within the channel. It also presents each framing bit with the number of the frame it belongs to, and each data link bit on a strobe of its own. From these strobes the block forms alarm intervals, and a persistence filter turns them into a stable alarm status.

The framing format (12-frame superframe or extended superframe) and a select input together pick one of four alarm encodings. In two of them every channel carries bit 2 as zero. One uses the framing bit of frame 12. In the last, the data link carries the repeating 16-bit pattern of eight ones and eight zeros. Any change of format or select restarts detection, so an alarm state is never built from evidence gathered under the wrong rules.

Top module: `t1_yellow_detect`

## Requirements
- R1: Reset (rst_n low at a rising edge) clears the alarm status to 0, and it stays 0 until enough alarm intervals arrive.
- R2: With esf_mode=0/alt_sel=0 or esf_mode=1/alt_sel=1 each frame is one interval. A frame begins at the payload strobe with chan_idx=0, bit_idx=1 and ends at the payload strobe with chan_idx=23, bit_idx=7. bit_idx=1 is bit 2 of the channel. The frame indicates alarm only if rx_bit was 0 at bit_idx=1 in every channel, and a 1 in any single channel, including channel 0 or channel 23, makes it clean.
- R3: With esf_mode=0/alt_sel=1 each framing strobe with frame_num=11 (frame 12, frame_num counted from 0) is one interval: fs_bit=1 indicates alarm and fs_bit=0 is clean. Framing strobes for any other frame are ignored.
- R4: With esf_mode=1/alt_sel=0 each data link bit is one interval, counted once 16 bits have arrived since the last clear. The interval indicates alarm when the last 16 bits are any cyclic rotation of eight ones followed by eight zeros.
- R5: The alarm status goes from 0 to 1 after PERSIST (default 4) consecutive alarm intervals. A clean interval restarts that count.
- R6: The alarm status goes from 1 to 0 after PERSIST consecutive clean intervals. An alarm interval restarts that count.
- R7: A change of esf_mode or alt_sel clears the pattern detectors and the persistence count but keeps the alarm status.
- R8: Strobes that the selected encoding does not use (payload bits, framing bits or data link bits) have no effect on the alarm status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| esf_mode | input | 1 | 0 = 12-frame superframe, 1 = extended superframe |
| alt_sel | input | 1 | Selects the alternative alarm encoding |
| bit_valid | input | 1 | Payload bit strobe |
| rx_bit | input | 1 | Payload bit value |
| chan_idx | input | 5 | Channel index 0..23 of the payload bit |
| bit_idx | input | 3 | Bit index 0..7 within the channel (1 = bit 2) |
| fs_valid | input | 1 | Framing bit strobe |
| fs_bit | input | 1 | Framing bit value |
| frame_num | input | 5 | Frame number within the multiframe, from 0 |
| dl_valid | input | 1 | Data link bit strobe |
| dl_bit | input | 1 | Data link bit value |
| yellow_alarm | output | 1 | Integrated remote alarm status |

## Verification
Every detector registers its interval result one clock after the strobe that completes the interval. The persistence filter updates the status on the next clock. The status is therefore due at the second rising edge after the last strobe of an interval. The bench drives strobes on falling edges, lets at least three idle clocks pass after a stimulus group, and samples yellow_alarm on a falling edge, so every check lands after the status is due. Mode changes are likewise followed by idle clocks before new strobes, so the clear has taken effect before any interval is counted.

// File: rtl/t1ya_pkg.sv
// Package: shared mode type for the remote alarm detector.
// Assumes: the format bit and select bit are decoded only here.
package t1ya_pkg;

    typedef enum logic [1:0] {
        MODE_SF_BIT2  = 2'b00,
        MODE_SF_FS12  = 2'b01,
        MODE_ESF_DL   = 2'b10,
        MODE_ESF_BIT2 = 2'b11
    } mode_e;

    // Map format and select onto the alarm encoding in use.
    function automatic mode_e decode_mode(input logic esf, input logic sel);
        return mode_e'({esf, sel});
    endfunction

endpackage

// File: rtl/t1ya_bit2_scan.sv
// Module: per-frame bit-2 scanner.
// Emits one interval per frame. The interval indicates alarm when no channel
// carried a 1 in the watched bit position.
// Assumes: strobes arrive in channel/bit order. A frame counts only if
// its start (channel 0, watched bit) was seen since the last clear.
module t1ya_bit2_scan #(
    parameter int NUM_CHAN  = 24,
    parameter int CH_W      = 5,
    parameter int BIT_W     = 3,
    parameter int WATCH_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_valid,
    input  logic             rx_bit,
    input  logic [CH_W-1:0]  chan_idx,
    input  logic [BIT_W-1:0] bit_idx,
    output logic             ev_tick,
    output logic             ev_hit
);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CHAN - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = {BIT_W{1'b1}};
    localparam logic [BIT_W-1:0] WBIT     = BIT_W'(WATCH_BIT);

    logic started;
    logic seen_one;
    logic at_watch;
    logic at_start;
    logic at_end;

    assign at_watch = bit_valid && (bit_idx == WBIT);
    assign at_start = at_watch && (chan_idx == '0);
    assign at_end   = bit_valid && (chan_idx == LAST_CH) && (bit_idx == LAST_BIT);

    // Track frame start and any watched bit equal to 1; evaluate at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            started  <= 1'b0;
            seen_one <= 1'b0;
            ev_tick  <= 1'b0;
            ev_hit   <= 1'b0;
        end else begin
            ev_tick <= 1'b0;
            ev_hit  <= 1'b0;
            if (at_start) begin
                started  <= 1'b1;
                seen_one <= rx_bit;
            end else if (at_watch && rx_bit) begin
                seen_one <= 1'b1;
            end
            if (at_end) begin
                ev_tick  <= started;
                ev_hit   <= started && !seen_one;
                started  <= 1'b0;
                seen_one <= 1'b0;
            end
        end
    end

    AST_TICK_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tick |-> $past(bit_valid && chan_idx == LAST_CH && bit_idx == LAST_BIT)); // R2
    AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit |-> ev_tick); // R2

endmodule

// File: rtl/t1ya_fs_check.sv
// Module: framing-bit alarm check.
// Emits one interval per multiframe, taken from the framing bit of the
// selected frame. A 1 in that bit indicates alarm.
// Assumes: frame_num is valid whenever fs_valid is high.
module t1ya_fs_check #(
    parameter int FRM_W    = 5,
    parameter int FS_FRAME = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fs_valid,
    input  logic             fs_bit,
    input  logic [FRM_W-1:0] frame_num,
    output logic             ev_tick,
    output logic             ev_hit
);
    localparam logic [FRM_W-1:0] SEL_FRAME = FRM_W'(FS_FRAME);

    // Register one interval for each framing bit of the selected frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ev_tick <= 1'b0;
            ev_hit  <= 1'b0;
        end else begin
            ev_tick <= fs_valid && (frame_num == SEL_FRAME);
            ev_hit  <= fs_valid && (frame_num == SEL_FRAME) && fs_bit;
        end
    end

    AST_FS_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tick |-> $past(fs_valid && frame_num == SEL_FRAME)); // R3

endmodule

// File: rtl/t1ya_dl_pattern.sv
// Module: data link pattern matcher.
// Keeps the last PAT_LEN data link bits. Once the window is full, each new
// bit is one interval, which indicates alarm when the window is any cyclic
// rotation of PAT_LEN/2 ones followed by PAT_LEN/2 zeros.
// Assumes: the pattern phase is unknown, so all rotations are accepted.
module t1ya_dl_pattern #(
    parameter int PAT_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic dl_valid,
    input  logic dl_bit,
    output logic ev_tick,
    output logic ev_hit
);
    localparam int HALF   = PAT_LEN / 2;
    localparam int FILL_W = $clog2(PAT_LEN + 1);
    localparam logic [PAT_LEN-1:0] BASE = {{HALF{1'b1}}, {(PAT_LEN - HALF){1'b0}}};
    localparam logic [FILL_W-1:0]  FULL = FILL_W'(PAT_LEN);

    logic [PAT_LEN-1:0] win;
    logic [PAT_LEN-1:0] win_next;
    logic [FILL_W-1:0]  fill;
    logic [PAT_LEN-1:0] rot_match;
    logic               full_next;

    assign win_next  = {win[PAT_LEN-2:0], dl_bit};
    assign full_next = (fill >= FULL - 1'b1);

    // One comparator per rotation of the alarm pattern.
    for (genvar k = 0; k < PAT_LEN; k++) begin : g_rot
        localparam logic [PAT_LEN-1:0] ROT =
            (k == 0) ? BASE : ((BASE << k) | (BASE >> (PAT_LEN - k)));
        assign rot_match[k] = (win_next == ROT);
    end

    // Shift in data link bits, count the fill and register the interval result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win     <= '0;
            fill    <= '0;
            ev_tick <= 1'b0;
            ev_hit  <= 1'b0;
        end else begin
            ev_tick <= 1'b0;
            ev_hit  <= 1'b0;
            if (dl_valid) begin
                win     <= win_next;
                if (fill != FULL) fill <= fill + 1'b1;
                ev_tick <= full_next;
                ev_hit  <= full_next && (|rot_match);
            end
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL); // R4
    AST_DL_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tick |-> $past(dl_valid)); // R4

endmodule

// File: rtl/t1ya_persist.sv
// Module: persistence filter.
// Flips the status after PERSIST consecutive intervals that disagree with
// it. An agreeing interval restarts the count, and clr restarts the count
// without touching the status.
// Assumes: PERSIST >= 1.
module t1ya_persist #(
    parameter int PERSIST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic hit,
    output logic status
);
    localparam int CNT_W = $clog2(PERSIST + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERSIST - 1);

    logic [CNT_W-1:0] cnt;

    // Count disagreeing intervals and flip the status at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            status <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            if (hit == status) begin
                cnt <= '0;
            end else if (cnt == LIMIT) begin
                status <= hit;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT); // R5
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(status)); // R8
    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(tick && hit)); // R5
    AST_CLEAR_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status) |-> $past(tick && !hit)); // R6
    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R7

endmodule

// File: rtl/t1_yellow_detect.sv
// Module: T1 remote alarm detector (top).
// Decodes the alarm encoding from format and select and routes strobes only
// to the detector that encoding uses. It selects that detector's intervals
// and filters them into a persistent alarm status.
// Assumes: the stream is already frame aligned. A change of format or select
// clears the detectors and the persistence count for one cycle.
module t1_yellow_detect #(
    parameter int NUM_CHAN = 24,
    parameter int CH_W     = 5,
    parameter int BIT_W    = 3,
    parameter int FRM_W    = 5,
    parameter int FS_FRAME = 11,
    parameter int PAT_LEN  = 16,
    parameter int PERSIST  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             esf_mode,
    input  logic             alt_sel,
    input  logic             bit_valid,
    input  logic             rx_bit,
    input  logic [CH_W-1:0]  chan_idx,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             fs_valid,
    input  logic             fs_bit,
    input  logic [FRM_W-1:0] frame_num,
    input  logic             dl_valid,
    input  logic             dl_bit,
    output logic             yellow_alarm
);
    import t1ya_pkg::*;

    mode_e mode;
    mode_e mode_q;
    logic  cfg_clr;
    logic  use_bit2, use_fs, use_dl;
    logic  b2_tick, b2_hit, fs_tick, fs_hit, dl_tick, dl_hit;
    logic  sel_tick, sel_hit;

    assign mode     = decode_mode(esf_mode, alt_sel);
    assign cfg_clr  = (mode != mode_q);
    assign use_bit2 = (mode == MODE_SF_BIT2) || (mode == MODE_ESF_BIT2);
    assign use_fs   = (mode == MODE_SF_FS12);
    assign use_dl   = (mode == MODE_ESF_DL);

    // Remember the configuration to detect changes.
    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    t1ya_bit2_scan #(
        .NUM_CHAN (NUM_CHAN),
        .CH_W     (CH_W),
        .BIT_W    (BIT_W),
        .WATCH_BIT(1)
    ) u_bit2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_clr),
        .bit_valid(bit_valid && use_bit2 && !cfg_clr),
        .rx_bit   (rx_bit),
        .chan_idx (chan_idx),
        .bit_idx  (bit_idx),
        .ev_tick  (b2_tick),
        .ev_hit   (b2_hit)
    );

    t1ya_fs_check #(
        .FRM_W   (FRM_W),
        .FS_FRAME(FS_FRAME)
    ) u_fs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_clr),
        .fs_valid (fs_valid && use_fs && !cfg_clr),
        .fs_bit   (fs_bit),
        .frame_num(frame_num),
        .ev_tick  (fs_tick),
        .ev_hit   (fs_hit)
    );

    t1ya_dl_pattern #(
        .PAT_LEN(PAT_LEN)
    ) u_dl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_clr),
        .dl_valid(dl_valid && use_dl && !cfg_clr),
        .dl_bit  (dl_bit),
        .ev_tick (dl_tick),
        .ev_hit  (dl_hit)
    );

    // Pick the interval stream of the active encoding.
    always_comb begin
        unique case (mode)
            MODE_SF_FS12: begin sel_tick = fs_tick; sel_hit = fs_hit; end
            MODE_ESF_DL:  begin sel_tick = dl_tick; sel_hit = dl_hit; end
            default:      begin sel_tick = b2_tick; sel_hit = b2_hit; end
        endcase
    end

    t1ya_persist #(
        .PERSIST(PERSIST)
    ) u_persist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_clr),
        .tick  (sel_tick),
        .hit   (sel_hit),
        .status(yellow_alarm)
    );

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({b2_tick, fs_tick, dl_tick}) <= 1); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !yellow_alarm); // R1

endmodule

// File: tb/t1_yellow_detect_bench.sv
// Bench: table-driven walk through all four encodings, then directed
// tests for clearing on configuration change, ignored strobes and reset.
module t1_yellow_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       esf_mode = 1'b0, alt_sel = 1'b0;
    logic       bit_valid = 1'b0, rx_bit = 1'b0;
    logic [4:0] chan_idx = '0;
    logic [2:0] bit_idx = '0;
    logic       fs_valid = 1'b0, fs_bit = 1'b0;
    logic [4:0] frame_num = '0;
    logic       dl_valid = 1'b0, dl_bit = 1'b0;
    logic       yellow_alarm;

    int checks = 0;
    int errors = 0;
    int dl_ph  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    t1_yellow_detect u_t1_yellow_detect (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .alt_sel(alt_sel),
        .bit_valid(bit_valid), .rx_bit(rx_bit), .chan_idx(chan_idx),
        .bit_idx(bit_idx), .fs_valid(fs_valid), .fs_bit(fs_bit),
        .frame_num(frame_num), .dl_valid(dl_valid), .dl_bit(dl_bit),
        .yellow_alarm(yellow_alarm)
    );

    // Stimulus kinds for the table.
    localparam int K_ALARM_FRM = 0;
    localparam int K_CLEAN_FRM = 1;
    localparam int K_FS12_ONE  = 2;
    localparam int K_FS12_ZERO = 3;
    localparam int K_DL_PAT    = 4;
    localparam int K_DL_ALT    = 5;

    // Entry: {esf, sel, kind[2:0], count[7:0], expected}, PERSIST = 4.
    localparam int NV = 10;
    localparam logic [13:0] TBL [NV] = '{
        {1'b0, 1'b0, 3'(K_ALARM_FRM),  8'd3, 1'b0}, // R5 below threshold
        {1'b0, 1'b0, 3'(K_ALARM_FRM),  8'd1, 1'b1}, // R2 R5 fourth alarm frame
        {1'b0, 1'b0, 3'(K_CLEAN_FRM),  8'd3, 1'b1}, // R6 below threshold
        {1'b0, 1'b0, 3'(K_CLEAN_FRM),  8'd1, 1'b0}, // R2 R6 fourth clean frame
        {1'b0, 1'b1, 3'(K_FS12_ONE),   8'd4, 1'b1}, // R3 R7
        {1'b0, 1'b1, 3'(K_FS12_ZERO),  8'd4, 1'b0}, // R3 R6
        {1'b1, 1'b0, 3'(K_DL_PAT),    8'd18, 1'b0}, // R4 three windows only
        {1'b1, 1'b0, 3'(K_DL_PAT),     8'd1, 1'b1}, // R4 fourth window
        {1'b1, 1'b0, 3'(K_DL_ALT),     8'd8, 1'b0}, // R4 R6
        {1'b1, 1'b1, 3'(K_ALARM_FRM),  8'd4, 1'b1}  // R2 ESF bit-2 mode
    };

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input bit alarm, input int one_chan);
        for (int ch = 0; ch < 24; ch++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                bit_valid = 1'b1;
                chan_idx  = 5'(ch);
                bit_idx   = 3'(b);
                rx_bit    = (b == 1) ? (!alarm && ch == one_chan) : 1'b1;
            end
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_fs(input int frm, input bit val);
        @(negedge clk);
        fs_valid  = 1'b1;
        frame_num = 5'(frm);
        fs_bit    = val;
        @(negedge clk);
        fs_valid = 1'b0;
    endtask

    task automatic send_dl(input bit val);
        @(negedge clk);
        dl_valid = 1'b1;
        dl_bit   = val;
        @(negedge clk);
        dl_valid = 1'b0;
    endtask

    task automatic send_dl_pat();
        send_dl(dl_ph < 8);
        dl_ph = (dl_ph + 1) % 16;
    endtask

    task automatic set_mode(input bit esf, input bit sel);
        @(negedge clk);
        esf_mode = esf;
        alt_sel  = sel;
        idle(2);
    endtask

    task automatic check(input string req, input bit exp);
        idle(3);
        checks++;
        if (yellow_alarm !== exp) begin
            errors++;
            $display("FAIL %s yellow_alarm=%0b expected=%0b", req, yellow_alarm, exp);
        end
    endtask

    task automatic run_kind(input int kind, input int n);
        for (int i = 0; i < n; i++) begin
            case (kind)
                K_ALARM_FRM: send_frame(1'b1, 0);
                K_CLEAN_FRM: send_frame(1'b0, (i * 7) % 24);
                K_FS12_ONE:  send_fs(11, 1'b1);
                K_FS12_ZERO: send_fs(11, 1'b0);
                K_DL_PAT:    send_dl_pat();
                default:     send_dl(i[0] == 1'b0);
            endcase
        end
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 1'b0); // reset state

        // Table walk: each entry checked against its expected status.
        for (int v = 0; v < NV; v++) begin
            if (TBL[v][13] != esf_mode || TBL[v][12] != alt_sel)
                set_mode(TBL[v][13], TBL[v][12]);
            run_kind(int'(TBL[v][11:9]), int'(TBL[v][8:1]));
            check($sformatf("R2-6 vector %0d", v), TBL[v][0]);
        end

        // R7: config change restarts the clean count and keeps the status.
        send_frame(1'b0, 0);
        send_frame(1'b0, 23);
        send_frame(1'b0, 23);
        set_mode(1'b1, 1'b0);
        set_mode(1'b1, 1'b1);
        check("R7 status kept", 1'b1);
        run_kind(K_CLEAN_FRM, 3);
        check("R7 count restarted", 1'b1);
        send_frame(1'b0, 23);
        check("R2 R6 one in channel 23", 1'b0);

        // R8: framing and data link strobes ignored in bit-2 mode.
        run_kind(K_FS12_ONE, 6);
        run_kind(K_DL_PAT, 40);
        check("R8 bit-2 mode ignores fs/dl", 1'b0);

        // R3: framing bits of other frames ignored.
        set_mode(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) send_fs(5, 1'b1);
        check("R3 other frame ignored", 1'b0);

        // R8: payload strobes ignored in framing-bit mode.
        run_kind(K_ALARM_FRM, 5);
        check("R8 fs mode ignores payload", 1'b0);

        // R5: clean interval restarts the set count.
        run_kind(K_FS12_ONE, 3);
        send_fs(11, 1'b0);
        run_kind(K_FS12_ONE, 3);
        check("R5 restart by clean", 1'b0);
        send_fs(11, 1'b1);
        check("R5 set after four", 1'b1);

        // R1: reset while alarmed.
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R1 reset clears", 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule